// File: doc/BRIEF.md
# Speculation-Tagged Register File

This block is a register file for a pipeline that runs instructions ahead of their controlling branch. Each entry holds a data word, a poison flag that marks the value as the product of speculation not yet resolved, and a deferred-fault flag. A write from a speculative instruction, or from one whose source operands were already poisoned, marks its destination as poisoned. If such a write also reports a fault, the fault is stored with the destination register and is not signalled.

The pipeline later resolves the speculation with a check operation on a register. A confirmed check on a register that holds a deferred fault raises the exception output for one cycle and names the register. A cancelled check, or a confirmed check on a register with no fault, clears the poison and fault flags. Register 0 is hard-wired to zero and is never poisoned. Both read ports are combinational and forward a write that is in flight in the same cycle.

Top module: `spec_regfile`

## Requirements
- R1: After reset every register reads as zero with its poison flag low, and exc_o is low.
- R2: Register 0 always reads as zero with poison low. Writes to it are ignored, and a check on it never raises exc_o.
- R3: Each of the two read ports returns, in the same cycle, the stored data and poison flag of the register at its address, independently of the other port.
- R4: When a write is enabled to a nonzero register, a read of that register in the same cycle returns the write data and the poison flag the write will store.
- R5: A write with wr_spec_i high stores its data and sets the destination's poison flag.
- R6: A non-speculative write with wr_src_poison_i high also sets the destination's poison flag.
- R7: A write with wr_spec_i and wr_src_poison_i both low clears the destination's poison and fault flags. Its wr_fault_i is not recorded, so a later confirmed check on that register raises nothing.
- R8: A poisoned write (R5 or R6) with wr_fault_i high records a deferred fault in the destination and does not raise exc_o.
- R9: A check with chk_confirm_i high on a register whose fault flag is set drives exc_o high for exactly the next cycle, with exc_reg_o equal to the checked index. The register's flags are left unchanged.
- R10: A check with chk_confirm_i low, or a confirmed check on a register with no fault, clears that register's poison and fault flags and does not raise exc_o.
- R11: When a write and a check target the same register in the same cycle, the flags stored by the write prevail. exc_o is decided from the flags held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| rd0_addr_i | input | 5 | Read port 0 register index |
| rd0_data_o | output | 64 | Read port 0 data |
| rd0_poison_o | output | 1 | Read port 0 poison flag |
| rd1_addr_i | input | 5 | Read port 1 register index |
| rd1_data_o | output | 64 | Read port 1 data |
| rd1_poison_o | output | 1 | Read port 1 poison flag |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write destination index |
| wr_data_i | input | 64 | Write data |
| wr_spec_i | input | 1 | Writing instruction is speculative |
| wr_src_poison_i | input | 1 | A source operand of the writing instruction was poisoned |
| wr_fault_i | input | 1 | The writing instruction faulted |
| chk_valid_i | input | 1 | Check operation valid |
| chk_addr_i | input | 5 | Register index to check |
| chk_confirm_i | input | 1 | 1: speculation confirmed, 0: cancelled |
| exc_o | output | 1 | One-cycle pulse raising a deferred exception |
| exc_reg_o | output | 5 | Register whose deferred exception is raised |

## Verification
Read data and poison are combinational, so the bench samples them 1 ns after driving addresses, with no clock edge in between. This holds for the forwarding case too, where the write is still pending. Register flags change at the first rising edge after a write or check. The exception pulse and its index are registered and appear in the cycle after the check's edge. The bench drives every operation at a falling edge, updates its model at the next rising edge, and compares exc_o and exc_reg_o at the falling edge that follows. Stored flags are checked only through later reads and confirmed checks.

// File: rtl/spec_rf_pkg.sv
package spec_rf_pkg;

  // Per-entry speculation state stored next to the data word.
  typedef struct packed {
    logic poison;
    logic fault;
  } tag_t;

endpackage

// File: rtl/spec_rf_tag_next.sv
module spec_rf_tag_next
  import spec_rf_pkg::*;
(
  input  logic spec_i,
  input  logic src_poison_i,
  input  logic fault_i,
  output tag_t tag_o
);

  logic poisoned;

  always_comb begin
    poisoned     = spec_i | src_poison_i;
    tag_o.poison = poisoned;
    // A fault is only kept when it must be deferred; clean writes drop it.
    tag_o.fault  = poisoned & fault_i;
  end

endmodule

// File: rtl/spec_rf_read_port.sv
module spec_rf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [DATA_W-1:0]   data_q_i [NUM_REGS],
  input  logic [NUM_REGS-1:0] poison_vec_i,
  input  logic                byp_en_i,
  input  logic [AW-1:0]       byp_addr_i,
  input  logic [DATA_W-1:0]   byp_data_i,
  input  logic                byp_poison_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                poison_o
);

  logic hit;

  always_comb begin
    hit = byp_en_i && (byp_addr_i == addr_i);
    if (hit) begin
      data_o   = byp_data_i;
      poison_o = byp_poison_i;
    end else if (addr_i == '0) begin
      data_o   = '0;
      poison_o = 1'b0;
    end else begin
      data_o   = data_q_i[addr_i];
      poison_o = poison_vec_i[addr_i];
    end
  end

endmodule

// File: rtl/spec_rf_check.sv
module spec_rf_check #(
  parameter int NUM_REGS = 32,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input  logic                valid_i,
  input  logic                confirm_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [NUM_REGS-1:0] fault_vec_i,
  output logic                raise_o,
  output logic                clear_o
);

  logic live;

  always_comb begin
    live    = valid_i && (addr_i != '0);
    raise_o = live && confirm_i && fault_vec_i[addr_i];
    clear_o = live && !raise_o;
  end

endmodule

// File: rtl/spec_regfile.sv
module spec_regfile
  import spec_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic [$clog2(NUM_REGS)-1:0]  rd0_addr_i,
  output logic [DATA_W-1:0]            rd0_data_o,
  output logic                         rd0_poison_o,
  input  logic [$clog2(NUM_REGS)-1:0]  rd1_addr_i,
  output logic [DATA_W-1:0]            rd1_data_o,
  output logic                         rd1_poison_o,
  input  logic                         wr_en_i,
  input  logic [$clog2(NUM_REGS)-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         wr_spec_i,
  input  logic                         wr_src_poison_i,
  input  logic                         wr_fault_i,
  input  logic                         chk_valid_i,
  input  logic [$clog2(NUM_REGS)-1:0]  chk_addr_i,
  input  logic                         chk_confirm_i,
  output logic                         exc_o,
  output logic [$clog2(NUM_REGS)-1:0]  exc_reg_o
);

  localparam int AW       = $clog2(NUM_REGS);
  localparam int RD_PORTS = 2;

  logic [DATA_W-1:0]   data_q [NUM_REGS];
  tag_t                tag_q  [NUM_REGS];
  logic [NUM_REGS-1:0] poison_vec;
  logic [NUM_REGS-1:0] fault_vec;

  logic wr_hit;
  tag_t wr_tag;
  logic chk_raise;
  logic chk_clear;

  logic exc_d, exc_q;
  logic [AW-1:0] exc_reg_d, exc_reg_q;
  logic exc_reg_en;

  assign wr_hit = wr_en_i && (wr_addr_i != '0);

  spec_rf_tag_next u_tag_next (
    .spec_i       (wr_spec_i),
    .src_poison_i (wr_src_poison_i),
    .fault_i      (wr_fault_i),
    .tag_o        (wr_tag)
  );

  spec_rf_check #(.NUM_REGS(NUM_REGS), .AW(AW)) u_check (
    .valid_i     (chk_valid_i),
    .confirm_i   (chk_confirm_i),
    .addr_i      (chk_addr_i),
    .fault_vec_i (fault_vec),
    .raise_o     (chk_raise),
    .clear_o     (chk_clear)
  );

  // Storage entries; entry 0 is a constant zero.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign data_q[g] = '0;
      assign tag_q[g]  = '0;
    end else begin : g_live
      logic data_en;
      logic tag_en;
      tag_t tag_nxt;

      always_comb begin
        data_en = wr_hit && (wr_addr_i == AW'(g));
        tag_en  = data_en || (chk_clear && (chk_addr_i == AW'(g)));
        // Write tag wins over a same-cycle clear.
        tag_nxt = data_en ? wr_tag : '0;
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          data_q[g] <= '0;
          tag_q[g]  <= '0;
        end else begin
          if (data_en) data_q[g] <= wr_data_i;
          if (tag_en)  tag_q[g]  <= tag_nxt;
        end
      end
    end
    assign poison_vec[g] = tag_q[g].poison;
    assign fault_vec[g]  = tag_q[g].fault;
  end

  // Read ports.
  logic [AW-1:0]     rd_addr   [RD_PORTS];
  logic [DATA_W-1:0] rd_data   [RD_PORTS];
  logic              rd_poison [RD_PORTS];

  assign rd_addr[0] = rd0_addr_i;
  assign rd_addr[1] = rd1_addr_i;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    spec_rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)) u_port (
      .addr_i       (rd_addr[p]),
      .data_q_i     (data_q),
      .poison_vec_i (poison_vec),
      .byp_en_i     (wr_hit),
      .byp_addr_i   (wr_addr_i),
      .byp_data_i   (wr_data_i),
      .byp_poison_i (wr_tag.poison),
      .data_o       (rd_data[p]),
      .poison_o     (rd_poison[p])
    );
  end

  assign rd0_data_o   = rd_data[0];
  assign rd0_poison_o = rd_poison[0];
  assign rd1_data_o   = rd_data[1];
  assign rd1_poison_o = rd_poison[1];

  // Exception pulse register.
  always_comb begin
    exc_d      = chk_raise;
    exc_reg_en = chk_raise;
    exc_reg_d  = chk_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      exc_q     <= 1'b0;
      exc_reg_q <= '0;
    end else begin
      exc_q <= exc_d;
      if (exc_reg_en) exc_reg_q <= exc_reg_d;
    end
  end

  assign exc_o     = exc_q;
  assign exc_reg_o = exc_reg_q;

endmodule

// File: rtl/spec_regfile_chk.sv
module spec_regfile_chk #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  parameter int AW       = $clog2(NUM_REGS)
) (
  input logic                clk_i,
  input logic                rst_n_i,
  input logic [AW-1:0]       rd0_addr_i,
  input logic [DATA_W-1:0]   rd0_data_o,
  input logic                rd0_poison_o,
  input logic                wr_en_i,
  input logic [AW-1:0]       wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                wr_spec_i,
  input logic                wr_src_poison_i,
  input logic                wr_fault_i,
  input logic                chk_valid_i,
  input logic [AW-1:0]       chk_addr_i,
  input logic                chk_confirm_i,
  input logic                exc_o,
  input logic [AW-1:0]       exc_reg_o,
  input logic [NUM_REGS-1:0] poison_vec_i,
  input logic [NUM_REGS-1:0] fault_vec_i
);

  p_reg0_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !poison_vec_i[0] && !fault_vec_i[0] &&
    ((rd0_addr_i != '0) || (rd0_data_o == '0 && !rd0_poison_o)));

  p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && wr_addr_i != '0 && rd0_addr_i == wr_addr_i) |->
    (rd0_data_o == wr_data_i && rd0_poison_o == (wr_spec_i | wr_src_poison_i)));

  p_spec_poisons_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && wr_spec_i && wr_addr_i != '0) |=> poison_vec_i[$past(wr_addr_i)]);

  p_propagate_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && wr_src_poison_i && wr_addr_i != '0) |=> poison_vec_i[$past(wr_addr_i)]);

  p_clean_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && !wr_spec_i && !wr_src_poison_i && wr_addr_i != '0) |=>
    (!poison_vec_i[$past(wr_addr_i)] && !fault_vec_i[$past(wr_addr_i)]));

  p_defer_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && (wr_spec_i || wr_src_poison_i) && wr_fault_i && wr_addr_i != '0 &&
     !(chk_valid_i && chk_confirm_i)) |=> (!exc_o && fault_vec_i[$past(wr_addr_i)]));

  p_exc_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    exc_o |-> $past(chk_valid_i && chk_confirm_i && fault_vec_i[chk_addr_i]));

  p_exc_index_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    exc_o |-> (exc_reg_o == $past(chk_addr_i)));

  p_cancel_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (chk_valid_i && !chk_confirm_i && chk_addr_i != '0 &&
     !(wr_en_i && wr_addr_i == chk_addr_i)) |=>
    (!exc_o && !poison_vec_i[$past(chk_addr_i)] && !fault_vec_i[$past(chk_addr_i)]));

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && wr_spec_i && wr_addr_i != '0 && chk_valid_i && chk_addr_i == wr_addr_i) |=>
    poison_vec_i[$past(wr_addr_i)]);

endmodule

bind spec_regfile spec_regfile_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_n_i         (rst_n_i),
  .rd0_addr_i      (rd0_addr_i),
  .rd0_data_o      (rd0_data_o),
  .rd0_poison_o    (rd0_poison_o),
  .wr_en_i         (wr_en_i),
  .wr_addr_i       (wr_addr_i),
  .wr_data_i       (wr_data_i),
  .wr_spec_i       (wr_spec_i),
  .wr_src_poison_i (wr_src_poison_i),
  .wr_fault_i      (wr_fault_i),
  .chk_valid_i     (chk_valid_i),
  .chk_addr_i      (chk_addr_i),
  .chk_confirm_i   (chk_confirm_i),
  .exc_o           (exc_o),
  .exc_reg_o       (exc_reg_o),
  .poison_vec_i    (poison_vec),
  .fault_vec_i     (fault_vec)
);

// File: tb/tb_spec_regfile.sv
`timescale 1ns/1ps
module tb_spec_regfile;

  localparam int N  = 32;
  localparam int DW = 64;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] rd0_addr, rd1_addr, wr_addr, chk_addr;
  logic [DW-1:0] rd0_data, rd1_data, wr_data;
  logic          rd0_poison, rd1_poison;
  logic          wr_en, wr_spec, wr_srcp, wr_fault;
  logic          chk_valid, chk_confirm;
  logic          exc;
  logic [AW-1:0] exc_reg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [DW-1:0] m_data [N];
  logic          m_poi  [N];
  logic          m_flt  [N];

  always #4 clk = ~clk;

  spec_regfile #(.NUM_REGS(N), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_n_i(rst_n),
    .rd0_addr_i(rd0_addr), .rd0_data_o(rd0_data), .rd0_poison_o(rd0_poison),
    .rd1_addr_i(rd1_addr), .rd1_data_o(rd1_data), .rd1_poison_o(rd1_poison),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_spec_i(wr_spec), .wr_src_poison_i(wr_srcp), .wr_fault_i(wr_fault),
    .chk_valid_i(chk_valid), .chk_addr_i(chk_addr), .chk_confirm_i(chk_confirm),
    .exc_o(exc), .exc_reg_o(exc_reg)
  );

  function automatic logic [DW-1:0] pat(input int r, input int k);
    return {32'(r * 32'h01010101 + k * 32'h9e37), 32'(~(r * 7 + k * 13))};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Combinational read of two registers; called at a falling edge, no write pending.
  task automatic rd(input int a0, input int a1, input string req);
    rd0_addr = AW'(a0);
    rd1_addr = AW'(a1);
    #1;
    check(rd0_data == m_data[a0], {req, " port0 data"}, rd0_data, m_data[a0]);
    check(rd0_poison == m_poi[a0], {req, " port0 poison"}, DW'(rd0_poison), DW'(m_poi[a0]));
    check(rd1_data == m_data[a1], {req, " port1 data"}, rd1_data, m_data[a1]);
    check(rd1_poison == m_poi[a1], {req, " port1 poison"}, DW'(rd1_poison), DW'(m_poi[a1]));
  endtask

  // One cycle with an optional write and an optional check; starts and ends at a falling edge.
  task automatic op(input bit we, input int wa, input logic [DW-1:0] wd,
                    input bit ws, input bit wp, input bit wf,
                    input bit cv, input int ca, input bit cc, input string req);
    logic          exp_exc;
    logic [DW-1:0] byp_d;
    logic          byp_p;
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    wr_spec = ws; wr_srcp = wp; wr_fault = wf;
    chk_valid = cv; chk_addr = AW'(ca); chk_confirm = cc;
    if (we) begin
      rd0_addr = AW'(wa);
      #1;
      byp_d = (wa == 0) ? '0 : wd;
      byp_p = (wa == 0) ? 1'b0 : (ws | wp);
      check(rd0_data == byp_d, "R4 forwarded data", rd0_data, byp_d);
      check(rd0_poison == byp_p, "R4 forwarded poison", DW'(rd0_poison), DW'(byp_p));
    end
    @(posedge clk);
    exp_exc = cv && cc && (ca != 0) && m_flt[ca];
    if (cv && ca != 0 && !exp_exc) begin
      m_poi[ca] = 1'b0; m_flt[ca] = 1'b0;
    end
    if (we && wa != 0) begin
      m_data[wa] = wd; m_poi[wa] = ws | wp; m_flt[wa] = (ws | wp) & wf;
    end
    @(negedge clk);
    wr_en = 1'b0; chk_valid = 1'b0;
    check(exc == exp_exc, {req, " exc pulse"}, DW'(exc), DW'(exp_exc));
    if (exp_exc)
      check(exc_reg == AW'(ca), {req, " exc index"}, DW'(exc_reg), DW'(ca));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_data[i] = '0; m_poi[i] = 1'b0; m_flt[i] = 1'b0;
    end
    rst_n = 1'b0;
    wr_en = 0; wr_addr = '0; wr_data = '0; wr_spec = 0; wr_srcp = 0; wr_fault = 0;
    chk_valid = 0; chk_addr = '0; chk_confirm = 0; rd0_addr = '0; rd1_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(exc == 1'b0, "R1 exc after reset", DW'(exc), '0);
    for (int r = 0; r < N; r++) rd(r, N - 1 - r, "R1");

    // R2: register 0 ignores writes and checks
    op(1, 0, {DW{1'b1}}, 1, 0, 1, 0, 0, 0, "R2");
    rd(0, 0, "R2 after write");
    op(0, 0, '0, 0, 0, 0, 1, 0, 1, "R2 check on zero");

    // R5, R6, R8: sweep writes with mixed speculation kinds and faults
    for (int r = 1; r < N; r++)
      op(1, r, pat(r, 1), (r % 3) == 1, (r % 3) == 2, (r % 4) < 2, 0, 0, 0, "R8");
    // R3: read back through both ports
    for (int r = 0; r < N; r++) rd(r, N - 1 - r, "R3 R5 R6");

    // R9, R10: confirm odd registers, cancel even ones
    for (int r = 0; r < N; r++) op(0, 0, '0, 0, 0, 0, 1, r, (r % 2) == 1, "R9 R10");
    for (int r = 0; r < N; r++) rd(r, (r + 5) % N, "R9 R10 flags");
    // R9: flags unchanged, so confirming again raises again
    for (int r = 1; r < N; r += 2) op(0, 0, '0, 0, 0, 0, 1, r, 1, "R9 repeat");

    // R7: clean writes with fault asserted drop everything
    for (int r = 1; r < N; r++) op(1, r, pat(r, 2), 0, 0, 1, 0, 0, 0, "R7");
    for (int r = 0; r < N; r++) rd(r, r, "R7");
    for (int r = 1; r < N; r++) op(0, 0, '0, 0, 0, 0, 1, r, 1, "R7 confirm");

    // R11: write and check on the same register in the same cycle
    op(1, 7, pat(7, 3), 1, 0, 1, 0, 0, 0, "R11 setup");
    op(1, 7, pat(7, 4), 1, 0, 0, 1, 7, 0, "R11 cancel vs write");
    rd(7, 7, "R11 write prevails");
    op(1, 9, pat(9, 3), 0, 1, 1, 0, 0, 0, "R11 setup");
    op(1, 9, pat(9, 5), 0, 0, 0, 1, 9, 1, "R11 confirm uses old flags");
    rd(9, 7, "R11 clean write prevails");
    // back-to-back deferred exceptions on two registers
    op(1, 3, pat(3, 6), 1, 0, 1, 0, 0, 0, "R8 setup");
    op(1, 4, pat(4, 6), 0, 1, 1, 0, 0, 0, "R8 setup");
    op(0, 0, '0, 0, 0, 0, 1, 3, 1, "R9 first");
    op(0, 0, '0, 0, 0, 0, 1, 4, 1, "R9 second");
    op(0, 0, '0, 0, 0, 0, 1, 7, 1, "R10 confirm no fault");
    rd(7, 4, "R10 after confirm");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule